// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a three-wire stereo PCM stream (bit clock, frame clock, serial data) into parallel left and right samples on a fast system clock. It is always a slave: the bit clock and frame clock come from outside. The three serial wires pass through a synchronizer, and the chosen edge of the bit clock is detected in the system clock domain. A single shift register then collects the serial bits. A small slot counter decides which sample event ends a left word and which ends a right word, according to the selected framing.

Four framings are handled by the same datapath: left-justified, I2S, right-justified and a DSP pulse mode. Word lengths are 16, 20, 24 or 32 bits. Samples come out MSB-aligned in 24 bits, so the sign bit stays in bit 23. The configuration inputs come from an external register block. When the configuration changes, the receiver drops the partly assembled frame and waits for the next frame start. When both halves of a frame have been taken, the two samples appear together with a one-cycle strobe.

Top module: `pcm_serial_rx`

## Requirements
- R1: After reset, `left_out` and `right_out` are zero and `pair_valid` is low. No pair is produced until a frame start has been seen. A frame-clock transition is recognised only after at least one sample event has occurred since reset.
- R2: A sample event is a rising edge of `sclk_in` when `cfg_bclk_inv`=0 and a falling edge when it is 1. `frame_in` and `sdata_in` are taken only at sample events.
- R3: With `cfg_format`=0 (left-justified), the MSB is at the first sample event after a frame-clock transition. `frame_in` high carries the left word, and the frame starts when `frame_in` goes high.
- R4: With `cfg_format`=2 (I2S), the MSB is at the second sample event after a transition. `frame_in` low carries the left word, and the frame starts when `frame_in` goes low.
- R5: With `cfg_format`=1 (right-justified), a word's LSB is the last sample event before a frame-clock transition, and the word is sent MSB first. The word that ends when `frame_in` falls is the left word. The frame starts when `frame_in` goes high.
- R6: With `cfg_format`=3 (DSP), a frame starts at a rising edge of `frame_in`. The left MSB is at the first sample event of the frame when `cfg_dsp_early`=1 and at the second when it is 0. The right word follows the left word immediately, and falling edges of `frame_in` are ignored.
- R7: `cfg_wlen` selects the word length: 0=16, 1=20, 2=24, 3=32 bits. Shorter words are padded with zeros below the LSB to fill 24 bits. For 32-bit words only the upper 24 bits are kept.
- R8: Sample events outside the bit positions of a word have no effect on the outputs.
- R9: `pair_valid` pulses high for one cycle exactly SYNC_STAGES+1 system clocks after the sample event that ends the right word of a frame whose left word was also captured. Both outputs change only on that cycle.
- R10: A change on any configuration input drops a captured left word and suppresses output until the next frame start under the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_format | input | 2 | Framing select (0 LJ, 1 RJ, 2 I2S, 3 DSP) |
| cfg_wlen | input | 2 | Word length select (16/20/24/32) |
| cfg_bclk_inv | input | 1 | 1 = sample on falling bit-clock edge |
| cfg_dsp_early | input | 1 | DSP mode: 1 = MSB on first slot after frame pulse |
| sclk_in | input | 1 | Serial bit clock, asynchronous |
| frame_in | input | 1 | Frame / channel clock, asynchronous |
| sdata_in | input | 1 | Serial audio data, asynchronous |
| left_out | output | 24 | Left sample, MSB-aligned |
| right_out | output | 24 | Right sample, MSB-aligned |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench builds the receiver with SYNC_STAGES=2 and CNT_W=8. Two stages give a fixed three-clock latency from a driven bit-clock edge to the strobe, so the reference model can predict the exact cycle of every strobe. An 8-bit slot counter covers the 40-slot channel halves and the 80-slot DSP frames the bench sends, including the longest DSP case of 32-bit words with a one-slot offset. Random fill in the unused slots exercises R8 in every framing. Each clock, the bench compares the strobe and both samples against the behavioural model.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'd0,
    FMT_RIGHT = 2'd1,
    FMT_I2S   = 2'd2,
    FMT_DSP   = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    WL_16 = 2'd0,
    WL_20 = 2'd1,
    WL_24 = 2'd2,
    WL_32 = 2'd3
  } wlen_e;

  localparam int SAMPLE_W = 24;
  localparam int SHIFT_W  = 32;
  localparam int CFG_W    = 6;

  // number of serial bits carried by one word
  function automatic int unsigned word_bits(wlen_e wl);
    case (wl)
      WL_16:   return 16;
      WL_20:   return 20;
      WL_24:   return 24;
      default: return 32;
    endcase
  endfunction

  // place the newest word (LSB in bit 0 of sh) MSB-first into SAMPLE_W bits
  function automatic logic [SAMPLE_W-1:0] msb_align(logic [SHIFT_W-1:0] sh, wlen_e wl);
    case (wl)
      WL_16:   return {sh[15:0], 8'h00};
      WL_20:   return {sh[19:0], 4'h0};
      WL_24:   return sh[23:0];
      default: return sh[31:8];
    endcase
  endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
// Synchronizes the three serial wires and flags the selected bit-clock edge.
module pcm_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_fall,
  input  logic sclk_in,
  input  logic frame_in,
  input  logic sdata_in,
  output logic ev,
  output logic ev_lr,
  output logic ev_d
);

  localparam int LANES = 3;
  localparam int L_SCLK = 2;
  localparam int L_LR   = 1;
  localparam int L_DAT  = 0;

  logic [STAGES-1:0][LANES-1:0] pipe;
  logic [LANES-1:0]             raw;
  logic [LANES-1:0]             synced;
  logic                         sclk_last;

  assign raw = {sclk_in, frame_in, sdata_in};

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], raw};
      end
    end
  endgenerate

  assign synced = pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sclk_last <= 1'b0;
    else     sclk_last <= synced[L_SCLK];
  end

  assign ev    = sample_fall ? (sclk_last & ~synced[L_SCLK])
                             : (~sclk_last & synced[L_SCLK]);
  assign ev_lr = synced[L_LR];
  assign ev_d  = synced[L_DAT];

endmodule

// File: rtl/pcm_rx_framer.sv
// Tracks slot position relative to frame-clock edges and flags word ends.
module pcm_rx_framer
  import pcm_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  ev,
  input  logic  ev_lr,
  input  fmt_e  fmt,
  input  wlen_e wlen,
  input  logic  dsp_early,
  output logic  done_left,
  output logic  done_right,
  output logic  frame_start
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             lr_prev;
  logic             hist_ok;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_now;
  logic [CNT_W-1:0] w_c;
  logic [CNT_W-1:0] off_c;
  logic [CNT_W-1:0] end_lj;
  logic [CNT_W-1:0] end_dsp_l;
  logic [CNT_W-1:0] end_dsp_r;
  logic             trans;
  logic             rise;
  logic             restart;

  always_comb begin
    trans   = hist_ok & (ev_lr ^ lr_prev);
    rise    = trans & ev_lr;
    restart = (fmt == FMT_DSP) ? rise : trans;

    if (restart)             cnt_now = '0;
    else if (cnt_q == CNT_MAX) cnt_now = cnt_q;
    else                     cnt_now = cnt_q + ONE;

    w_c       = CNT_W'(word_bits(wlen));
    off_c     = dsp_early ? '0 : ONE;
    end_lj    = w_c - ONE;
    end_dsp_l = off_c + w_c - ONE;
    end_dsp_r = end_dsp_l + w_c;

    done_left  = 1'b0;
    done_right = 1'b0;
    case (fmt)
      FMT_LEFT: begin
        done_left  = ev & (cnt_now == end_lj) &  ev_lr;
        done_right = ev & (cnt_now == end_lj) & ~ev_lr;
      end
      FMT_I2S: begin
        done_left  = ev & (cnt_now == w_c) & ~ev_lr;
        done_right = ev & (cnt_now == w_c) &  ev_lr;
      end
      FMT_RIGHT: begin
        done_left  = ev & trans &  lr_prev;
        done_right = ev & trans & ~lr_prev;
      end
      default: begin
        done_left  = ev & (cnt_now == end_dsp_l);
        done_right = ev & (cnt_now == end_dsp_r);
      end
    endcase

    frame_start = ev & trans & (ev_lr == (fmt != FMT_I2S));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_prev <= 1'b0;
      hist_ok <= 1'b0;
      cnt_q   <= '0;
    end else if (ev) begin
      lr_prev <= ev_lr;
      hist_ok <= 1'b1;
      cnt_q   <= cnt_now;
    end
  end

endmodule

// File: rtl/pcm_rx_shift.sv
// Continuous serial-in shift register; presents the aligned newest word.
module pcm_rx_shift
  import pcm_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ev,
  input  logic                ev_d,
  input  wlen_e               wlen,
  input  logic                use_pre,
  output logic [SAMPLE_W-1:0] word
);

  logic [SHIFT_W-1:0] sh_q;
  logic [SHIFT_W-1:0] sh_next;

  assign sh_next = {sh_q[SHIFT_W-2:0], ev_d};
  assign word    = msb_align(use_pre ? sh_q : sh_next, wlen);

  always_ff @(posedge clk) begin
    if (rst)     sh_q <= '0;
    else if (ev) sh_q <= sh_next;
  end

endmodule

// File: rtl/pcm_rx_collect.sv
// Pairs left and right words, handles resynchronisation on config change.
module pcm_rx_collect
  import pcm_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CFG_W-1:0]    cfg,
  input  logic                done_left,
  input  logic                done_right,
  input  logic                frame_start,
  input  logic [SAMPLE_W-1:0] word,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                pair_valid
);

  logic [CFG_W-1:0]    cfg_q;
  logic                armed;
  logic                left_have;
  logic [SAMPLE_W-1:0] left_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= cfg;
      armed      <= 1'b0;
      left_have  <= 1'b0;
      left_hold  <= '0;
      left_out   <= '0;
      right_out  <= '0;
      pair_valid <= 1'b0;
    end else begin
      cfg_q      <= cfg;
      pair_valid <= 1'b0;
      if (cfg != cfg_q) begin
        armed     <= 1'b0;
        left_have <= 1'b0;
      end else begin
        if (armed && done_left) begin
          left_hold <= word;
          left_have <= 1'b1;
        end
        if (armed && done_right) begin
          left_have <= 1'b0;
          if (left_have) begin
            left_out   <= left_hold;
            right_out  <= word;
            pair_valid <= 1'b1;
          end
        end
        if (frame_start) armed <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_format,
  input  logic [1:0]          cfg_wlen,
  input  logic                cfg_bclk_inv,
  input  logic                cfg_dsp_early,
  input  logic                sclk_in,
  input  logic                frame_in,
  input  logic                sdata_in,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                pair_valid
);

  fmt_e                fmt;
  wlen_e               wlen;
  logic [CFG_W-1:0]    cfg_all;
  logic                ev;
  logic                ev_lr;
  logic                ev_d;
  logic                done_left;
  logic                done_right;
  logic                frame_start;
  logic [SAMPLE_W-1:0] word;

  assign fmt     = fmt_e'(cfg_format);
  assign wlen    = wlen_e'(cfg_wlen);
  assign cfg_all = {cfg_format, cfg_wlen, cfg_bclk_inv, cfg_dsp_early};

  pcm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .sample_fall (cfg_bclk_inv),
    .sclk_in     (sclk_in),
    .frame_in    (frame_in),
    .sdata_in    (sdata_in),
    .ev          (ev),
    .ev_lr       (ev_lr),
    .ev_d        (ev_d)
  );

  pcm_rx_framer #(.CNT_W(CNT_W)) u_framer (
    .clk         (clk),
    .rst         (rst),
    .ev          (ev),
    .ev_lr       (ev_lr),
    .fmt         (fmt),
    .wlen        (wlen),
    .dsp_early   (cfg_dsp_early),
    .done_left   (done_left),
    .done_right  (done_right),
    .frame_start (frame_start)
  );

  pcm_rx_shift u_shift (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .ev_d    (ev_d),
    .wlen    (wlen),
    .use_pre (fmt == FMT_RIGHT),
    .word    (word)
  );

  pcm_rx_collect u_collect (
    .clk         (clk),
    .rst         (rst),
    .cfg         (cfg_all),
    .done_left   (done_left),
    .done_right  (done_right),
    .frame_start (frame_start),
    .word        (word),
    .left_out    (left_out),
    .right_out   (right_out),
    .pair_valid  (pair_valid)
  );

endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  cfg_format,
  input logic [1:0]  cfg_wlen,
  input logic        cfg_bclk_inv,
  input logic        cfg_dsp_early,
  input logic [23:0] left_out,
  input logic [23:0] right_out,
  input logic        pair_valid
);

  logic [5:0] cfg_cat;
  assign cfg_cat = {cfg_format, cfg_wlen, cfg_bclk_inv, cfg_dsp_early};

  // R1: first cycle out of reset shows cleared outputs
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pair_valid && left_out == 24'd0 && right_out == 24'd0));

  // R9: strobe lasts a single cycle
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  // R9: samples move only with the strobe
  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (rst)
    !pair_valid |-> ($stable(left_out) && $stable(right_out)));

  // R10: a configuration change never yields a pair on the next cycle
  p_cfg_resync_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_cat != $past(cfg_cat)) |=> !pair_valid);

endmodule

bind pcm_serial_rx pcm_serial_rx_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_format    (cfg_format),
  .cfg_wlen      (cfg_wlen),
  .cfg_bclk_inv  (cfg_bclk_inv),
  .cfg_dsp_early (cfg_dsp_early),
  .left_out      (left_out),
  .right_out     (right_out),
  .pair_valid    (pair_valid)
);

// File: tb/tb_pcm_serial_rx.sv
module tb_pcm_serial_rx;

  localparam int SYNC  = 2;
  localparam int LAT   = SYNC + 1;
  localparam int HALF  = 3;
  localparam int SLOTS = 40;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cfg_format, cfg_wlen;
  logic        cfg_bclk_inv, cfg_dsp_early;
  logic        sclk_in, frame_in, sdata_in;
  logic [23:0] left_out, right_out;
  logic        pair_valid;

  always #4 clk = ~clk;

  pcm_serial_rx #(.SYNC_STAGES(SYNC), .CNT_W(8)) dut (
    .clk(clk), .rst(rst),
    .cfg_format(cfg_format), .cfg_wlen(cfg_wlen),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_dsp_early(cfg_dsp_early),
    .sclk_in(sclk_in), .frame_in(frame_in), .sdata_in(sdata_in),
    .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
  );

  int    cyc = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  int    seen = 0;
  bit    mon_on = 0;
  bit    finished = 0;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference state
  bit          m_lrp, m_hist, m_armed, m_lhave;
  int          m_cnt;
  logic [31:0] m_sh;
  logic [23:0] m_lhold;
  int          due_q[$];
  logic [23:0] exl_q[$];
  logic [23:0] exr_q[$];
  logic [23:0] exp_l = '0;
  logic [23:0] exp_r = '0;

  function automatic int wbits(logic [1:0] w);
    return (w == 2'd0) ? 16 : (w == 2'd1) ? 20 : (w == 2'd2) ? 24 : 32;
  endfunction

  function automatic logic [23:0] align(logic [31:0] v, int w);
    logic [31:0] m;
    m = (w == 32) ? v : (v << (32 - w));
    return m[31:8];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_ev(bit lr, bit d);
    bit trans, rel, dl, dr, fs;
    int w, off;
    logic [31:0] pre, post;
    logic [23:0] wd;
    w   = wbits(cfg_wlen);
    off = cfg_dsp_early ? 0 : 1;
    trans = m_hist && (lr != m_lrp);
    rel   = (cfg_format == 2'd3) ? (trans && lr) : trans;
    m_cnt = rel ? 0 : ((m_cnt < 255) ? m_cnt + 1 : 255);
    pre  = m_sh;
    post = {m_sh[30:0], d};
    case (cfg_format)
      2'd0: begin dl = (m_cnt == w - 1) && lr;  dr = (m_cnt == w - 1) && !lr; end
      2'd2: begin dl = (m_cnt == w) && !lr;     dr = (m_cnt == w) && lr;      end
      2'd1: begin dl = trans && m_lrp;          dr = trans && !m_lrp;         end
      default: begin dl = (m_cnt == off + w - 1); dr = (m_cnt == off + 2 * w - 1); end
    endcase
    wd = align((cfg_format == 2'd1) ? pre : post, w);
    fs = trans && (lr == (cfg_format != 2'd2));
    if (m_armed && dl) begin m_lhold = wd; m_lhave = 1; end
    if (m_armed && dr) begin
      if (m_lhave) begin due_q.push_back(cyc + LAT); exl_q.push_back(m_lhold); exr_q.push_back(wd); end
      m_lhave = 0;
    end
    if (fs) m_armed = 1;
    m_lrp  = lr;
    m_hist = 1;
    m_sh   = post;
  endtask

  // per-clock comparison against the model (R9 timing, scenario data)
  always @(negedge clk) begin
    if (mon_on) begin
      bit ev_exp;
      ev_exp = 0;
      while (due_q.size() > 0 && due_q[0] < cyc) begin
        void'(due_q.pop_front()); void'(exl_q.pop_front()); void'(exr_q.pop_front());
      end
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        ev_exp = 1;
        void'(due_q.pop_front());
        exp_l = exl_q.pop_front();
        exp_r = exr_q.pop_front();
      end
      if (pair_valid) seen++;
      chk({"R9 ", cur_req}, {15'd0, pair_valid, left_out, right_out},
          {15'd0, ev_exp, exp_l, exp_r});
    end
  end

  task automatic send_slot(bit lr, bit d);
    bit idle;
    idle = cfg_bclk_inv;
    @(posedge clk); #1;
    sclk_in = idle; frame_in = lr; sdata_in = d;
    repeat (HALF) @(posedge clk);
    #1;
    sclk_in = ~idle;
    model_ev(lr, d);
    repeat (HALF - 1) @(posedge clk);
  endtask

  task automatic send_frame(logic [31:0] lv, logic [31:0] rv);
    int w, off;
    w   = wbits(cfg_wlen);
    off = cfg_dsp_early ? 0 : 1;
    for (int s = 0; s < 2 * SLOTS; s++) begin
      int ch, p, q;
      logic [31:0] v;
      bit lr, d;
      ch = s / SLOTS;
      p  = s % SLOTS;
      v  = (ch != 0) ? rv : lv;
      d  = bit'($urandom % 2);
      case (cfg_format)
        2'd0: begin lr = (ch == 0); if (p < w) d = v[w - 1 - p]; end
        2'd2: begin lr = (ch == 1); if (p >= 1 && p <= w) d = v[w - p]; end
        2'd1: begin lr = (ch == 0); q = p - (SLOTS - w); if (q >= 0) d = v[w - 1 - q]; end
        default: begin
          lr = (s == 0);
          q  = s - off;
          if (q >= 0 && q < w) d = lv[w - 1 - q];
          else if (q >= w && q < 2 * w) d = rv[2 * w - 1 - q];
        end
      endcase
      send_slot(lr, d);
    end
  endtask

  task automatic set_cfg(logic [1:0] f, logic [1:0] w, bit inv, bit early);
    @(posedge clk); #1;
    if ({f, w, inv, early} != {cfg_format, cfg_wlen, cfg_bclk_inv, cfg_dsp_early}) begin
      m_armed = 0;
      m_lhave = 0;
    end
    cfg_format = f; cfg_wlen = w; cfg_bclk_inv = inv; cfg_dsp_early = early;
    repeat (3) @(posedge clk);
  endtask

  task automatic preamble();
    bit lvl;
    lvl = (cfg_format == 2'd2);
    for (int i = 0; i < 4; i++) send_slot(lvl, bit'($urandom % 2));
  endtask

  task automatic run_case(string req, logic [1:0] f, logic [1:0] w, bit inv, bit early);
    logic [31:0] lv, rv;
    int wl;
    set_cfg(f, w, inv, early);
    cur_req = req;
    wl = wbits(w);
    preamble();
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk);
    chk({"R1 no pair before frame start ", req}, 64'(seen), 64'd0);
    for (int k = 0; k < 3; k++) begin
      lv = $urandom; rv = $urandom;
      send_frame(lv, rv);
    end
    if (f == 2'd1) send_slot(1'b1, bit'($urandom % 2));
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk);
    chk({req, " R7 left"},  64'(left_out),  64'(align(lv, wl)));
    chk({req, " R7 right"}, 64'(right_out), 64'(align(rv, wl)));
    chk({req, " R8 pair count"}, 64'(seen), 64'd3);
    seen = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lv, rv;
    rst = 1'b1;
    cfg_format = 2'd0; cfg_wlen = 2'd2; cfg_bclk_inv = 1'b0; cfg_dsp_early = 1'b0;
    sclk_in = 1'b0; frame_in = 1'b0; sdata_in = 1'b0;
    m_lrp = 0; m_hist = 0; m_armed = 0; m_lhave = 0; m_cnt = 0; m_sh = '0; m_lhold = '0;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", {15'd0, pair_valid, left_out, right_out}, 64'd0);
    mon_on = 1;

    run_case("R3 LJ 24b",           2'd0, 2'd2, 1'b0, 1'b0);
    run_case("R4 I2S 16b",          2'd2, 2'd0, 1'b0, 1'b0);
    run_case("R5 RJ 20b",           2'd1, 2'd1, 1'b0, 1'b0);
    run_case("R6 DSP late 24b",     2'd3, 2'd2, 1'b0, 1'b0);
    run_case("R6 DSP early 16b",    2'd3, 2'd0, 1'b0, 1'b1);
    run_case("R2 LJ 32b fall edge", 2'd0, 2'd3, 1'b1, 1'b0);
    run_case("R2 I2S 20b fall",     2'd2, 2'd1, 1'b1, 1'b0);
    run_case("R5 RJ 32b",           2'd1, 2'd3, 1'b0, 1'b0);
    run_case("R6 DSP late 32b",     2'd3, 2'd3, 1'b1, 1'b0);

    // R10: change word length half way through a frame
    set_cfg(2'd0, 2'd2, 1'b0, 1'b0);
    cur_req = "R10";
    preamble();
    lv = $urandom; rv = $urandom;
    send_frame(lv, rv);
    for (int p = 0; p < SLOTS; p++) send_slot(1'b1, (p < 24) ? lv[23 - p] : 1'b0);
    set_cfg(2'd0, 2'd0, 1'b0, 1'b0);
    for (int p = 0; p < SLOTS; p++) send_slot(1'b0, (p < 16) ? rv[15 - p] : 1'b0);
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk);
    chk("R10 dropped pair after change", 64'(seen), 64'd1);
    chk("R10 outputs kept", 64'(left_out), 64'(align(lv, 24)));
    lv = $urandom; rv = $urandom;
    send_frame(lv, rv);
    repeat (LAT + 2) @(posedge clk);
    @(negedge clk);
    chk("R10 resync pair count", 64'(seen), 64'd2);
    chk("R10 R7 left after resync",  64'(left_out),  64'(align(lv, 16)));
    chk("R10 R7 right after resync", 64'(right_out), 64'(align(rv, 16)));

    mon_on = 0;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule